// File: doc/BRIEF.md
# Embedded-Code Sync Reconstructor

This block takes a 4:2:2 video word stream whose line and frame timing is carried inside the data as timing reference codes. It finds those codes and rebuilds a separate data-enable, horizontal sync and vertical sync. The video words leave the block after a fixed delay, so the rebuilt timing lines up with them. The output can then feed logic that expects discrete sync pins.

Each timing reference is four words. Three of them form a fixed preamble. The fourth carries flags that mark whether the code starts or ends an active line, and whether the line is in vertical blanking. Data-enable spans the words between a start code on a visible line and the following end code. The horizontal pulse is placed a programmed number of clocks after each end code and lasts a programmed number of clocks. The vertical pulse starts a programmed number of horizontal pulses after the frame's active area closes and lasts a programmed number of horizontal pulses. Each pulse has its own polarity control.

Top module: `embsync_rebuild`

## Requirements
- R1: While reset is held and on the first cycle after it, `de_o` and `vid_o` are 0, and `hs_o` and `vs_o` sit at their inactive levels, equal to `hs_inv` and `vs_inv`.
- R2: A timing reference is recognised when four consecutive words have the 8 most significant bits 0xFF, 0x00, 0x00, then a flag word whose bit 7 is 1. The 2 least significant bits of a 10-bit word take no part in the match. In the flag word's top 8 bits, bit 4 set means end code and clear means start code, and bit 5 set means vertical blanking.
- R3: `vid_o` repeats `vid_i` exactly 4 clocks later.
- R4: `de_o` is 1 from the output word that follows the flag word of a start code with bit 5 clear, up to and including the last word before the next end code. It is 0 on all four words of both kinds of code.
- R5: A start code with bit 5 set leaves `de_o` at 0 for the whole line.
- R6: Inside an active line, the words 0xFF, 0x00 followed by a word whose top 8 bits are not 0x00 do not end the line, and `de_o` stays 1.
- R7: On every end code, including those on blanking lines, the horizontal pulse becomes active `hs_gap` clocks after the output cycle that carries the code's first word, and stays active for `hs_width` clocks. A width of 0 gives no pulse.
- R8: `hs_inv` = 1 inverts `hs_o`, and `vs_inv` = 1 inverts `vs_o`. When a control bit is 0, its pulse is active-high.
- R9: Vertical counting starts at the first end code with bit 5 set after a code with bit 5 clear. After reset, the block behaves as if the last code had bit 5 set. The horizontal pulse leading edges from that end code onward are numbered from 0. The vertical pulse goes active with leading edge `vs_gap` and inactive with leading edge `vs_gap + vs_width`, in the same clock as those edges.
- R10: A `vs_width` of 0, or an `hs_width` of 0, gives no vertical pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel word clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | DATA_W | Luma-aligned video word with embedded codes |
| hs_gap | input | CNT_W | Clocks from end code to horizontal pulse |
| hs_width | input | CNT_W | Horizontal pulse length in clocks |
| vs_gap | input | CNT_W | Horizontal pulses from blanking start to vertical pulse |
| vs_width | input | CNT_W | Vertical pulse length in horizontal pulses |
| hs_inv | input | 1 | Invert horizontal output |
| vs_inv | input | 1 | Invert vertical output |
| vid_o | output | DATA_W | Delayed video word |
| de_o | output | 1 | Rebuilt data enable |
| hs_o | output | 1 | Rebuilt horizontal sync |
| vs_o | output | 1 | Rebuilt vertical sync |

## Verification
The assertions assume a legal stream with these properties:
- Codes never overlap.
- Active data never forms a full preamble.
- `hs_gap + hs_width` fits inside the blanking part of each line.
- A new blanking start never arrives while a vertical pulse is still being counted.

The stimulus keeps to these rules. It builds eight-line frames with 16 non-enable words per line, keeps the horizontal window at most 7 clocks, keeps `vs_gap + vs_width` at 3 lines or fewer, and holds all controls fixed during each run. Within those limits it varies the code preamble's low bits, adds a partial preamble inside active data, and uses zero widths and both polarities.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

    localparam logic [7:0] TRS_LEAD = 8'hFF;
    localparam logic [7:0] TRS_NULL = 8'h00;

    // decoded timing reference, valid in the cycle the flag word arrives
    typedef struct packed {
        logic hit;     // full four-word code seen
        logic eav;     // end code (flag bit 4)
        logic vblank;  // vertical blanking flag (flag bit 5)
    } trs_ev_t;

    function automatic logic is_lead(input logic [7:0] b);
        return b == TRS_LEAD;
    endfunction

    function automatic logic is_null(input logic [7:0] b);
        return b == TRS_NULL;
    endfunction

endpackage

// File: rtl/trs_detect.sv
module trs_detect
    import embsync_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] vid_i,
    output logic [DATA_W-1:0] vid_o,
    output logic              de_o,
    output trs_ev_t           ev_o
);
    localparam int LAT = 4;          // total word latency, R3
    localparam int TOP = DATA_W - 1;

    logic [LAT-2:0][DATA_W-1:0] dly;  // [0] newest
    logic [LAT-1:0]             sav_tag;
    logic                       open_line;

    always_comb begin
        ev_o.hit    = is_lead(dly[LAT-2][TOP -: 8]) && is_null(dly[1][TOP -: 8])
                   && is_null(dly[0][TOP -: 8]) && vid_i[TOP];
        ev_o.eav    = ev_o.hit && vid_i[DATA_W-4];
        ev_o.vblank = vid_i[DATA_W-3];
        open_line   = ev_o.hit && !vid_i[DATA_W-4] && !vid_i[DATA_W-3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly     <= '0;
            vid_o   <= '0;
            sav_tag <= '0;
            de_o    <= 1'b0;
        end else begin
            dly     <= {dly[LAT-3:0], vid_i};
            vid_o   <= dly[LAT-2];
            sav_tag <= {sav_tag[LAT-2:0], open_line};
            if (ev_o.eav)
                de_o <= 1'b0;
            else if (sav_tag[LAT-1])
                de_o <= 1'b1;
        end
    end

    // R4: enable drops exactly on the first preamble word of an end code
    a_r4_de_falls_on_lead: assert property (@(posedge clk) disable iff (rst)
        $fell(de_o) |-> (vid_o[TOP -: 8] == TRS_LEAD));

    // R4: enable rises on the word after a visible start-code flag word
    a_r4_de_rises_after_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(de_o) |-> ($past(vid_o[TOP]) && !$past(vid_o[DATA_W-4])
                         && !$past(vid_o[DATA_W-3])));

endmodule

// File: rtl/hsync_timer.sv
module hsync_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] width,
    output logic             act,
    output logic             lead
);
    localparam int CW = CNT_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          run;

    always_comb begin
        lim  = {1'b0, gap} + {1'b0, width};
        act  = run && (cnt >= {1'b0, gap}) && (cnt < lim);
        lead = run && (cnt == {1'b0, gap}) && (width != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (line_start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (cnt >= lim)
                run <= 1'b0;
            else
                cnt <= cnt + CW'(1);
        end
    end

    // checker: length of the current pulse so far
    logic [CW-1:0] pulse_len;
    always_ff @(posedge clk) begin
        if (rst)
            pulse_len <= '0;
        else if (act)
            pulse_len <= pulse_len + CW'(1);
        else
            pulse_len <= '0;
    end

    // R7: a pulse never outlasts the programmed width
    a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
        act |-> (pulse_len < {1'b0, width}));

    // R7: zero width means silence
    a_r7_zero_width_quiet: assert property (@(posedge clk) disable iff (rst)
        (width == '0) |-> !act);

endmodule

// File: rtl/vsync_timer.sv
module vsync_timer
    import embsync_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  trs_ev_t          ev,
    input  logic             hs_lead,
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] width,
    output logic             act
);
    localparam int CW = CNT_W + 1;

    logic          v_prev;
    logic          run;
    logic [CW-1:0] cnt;     // horizontal leading edges seen so far
    logic [CW-1:0] lim;
    logic [CW-1:0] ln;      // index of the current line's leading edge
    logic          ln_ok;
    logic          start;

    always_comb begin
        start = ev.eav && ev.vblank && !v_prev;
        lim   = {1'b0, gap} + {1'b0, width};
        ln    = hs_lead ? cnt : cnt - CW'(1);
        ln_ok = hs_lead || (cnt != '0);
        act   = run && ln_ok && (ln >= {1'b0, gap}) && (ln < lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_prev <= 1'b1;
            run    <= 1'b0;
            cnt    <= '0;
        end else begin
            if (ev.hit)
                v_prev <= ev.vblank;
            if (start) begin
                run <= 1'b1;
                cnt <= '0;
            end else if (run && hs_lead) begin
                if (cnt >= lim)
                    run <= 1'b0;
                else
                    cnt <= cnt + CW'(1);
            end
        end
    end

    // R9: the vertical pulse only moves together with a horizontal leading edge
    a_r9_vs_moves_on_hs_lead: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> hs_lead);

    // R10: zero vertical width means no vertical pulse
    a_r10_zero_width_quiet: assert property (@(posedge clk) disable iff (rst)
        (width == '0) |-> !act);

endmodule

// File: rtl/embsync_rebuild.sv
module embsync_rebuild
    import embsync_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] vid_i,
    input  logic [CNT_W-1:0]  hs_gap,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic [CNT_W-1:0]  vs_gap,
    input  logic [CNT_W-1:0]  vs_width,
    input  logic              hs_inv,
    input  logic              vs_inv,
    output logic [DATA_W-1:0] vid_o,
    output logic              de_o,
    output logic              hs_o,
    output logic              vs_o
);
    trs_ev_t ev;
    logic    hs_act;
    logic    hs_lead;
    logic    vs_act;

    trs_detect #(.DATA_W(DATA_W)) u_det (
        .clk   (clk),
        .rst   (rst),
        .vid_i (vid_i),
        .vid_o (vid_o),
        .de_o  (de_o),
        .ev_o  (ev)
    );

    hsync_timer #(.CNT_W(CNT_W)) u_hs (
        .clk        (clk),
        .rst        (rst),
        .line_start (ev.eav),
        .gap        (hs_gap),
        .width      (hs_width),
        .act        (hs_act),
        .lead       (hs_lead)
    );

    vsync_timer #(.CNT_W(CNT_W)) u_vs (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .hs_lead (hs_lead),
        .gap     (vs_gap),
        .width   (vs_width),
        .act     (vs_act)
    );

    // R8: per-pulse polarity
    assign hs_o = hs_act ^ hs_inv;
    assign vs_o = vs_act ^ vs_inv;

    // R7: with a legal window the horizontal pulse sits in blanking
    a_r7_hs_outside_de: assert property (@(posedge clk) disable iff (rst)
        hs_act |-> !de_o);

endmodule

// File: tb/sim_embsync_rebuild.sv
module sim_embsync_rebuild;
    localparam int DW = 10;
    localparam int CW = 10;
    localparam int NLINE = 8;
    localparam int NBLANK = 8;
    localparam int NACT = 6;
    localparam int LEAD_IN = 3;
    localparam int TAIL = 20;
    localparam int MAXW = 256;
    localparam int BSTART = 4;   // first blanking line after the active area

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] vid = '0;
    logic [CW-1:0] hg = '0, hl = '0, vg = '0, vl = '0;
    logic          hinv = 1'b0, vinv = 1'b0;
    logic [DW-1:0] vid_o;
    logic          de_o, hs_o, vs_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int            stamp;
        logic [DW-1:0] d;
        logic          de, hs, vs;
        int            de_req, hs_req, vs_req;
    } item_t;

    item_t sb[$];

    logic [DW-1:0] stm [MAXW];
    logic          xde [MAXW];
    logic          xhs [MAXW];
    logic          xvs [MAXW];
    int            xreq[MAXW];
    int            eidx[NLINE];
    int            nwords;

    embsync_rebuild #(.DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .vid_i(vid),
        .hs_gap(hg), .hs_width(hl), .vs_gap(vg), .vs_width(vl),
        .hs_inv(hinv), .vs_inv(vinv),
        .vid_o(vid_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk_bit(input string what, input int req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic chk_word(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d vid_o actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // flag word: top 8 bits {1, F=0, V, H, 0000}
    function automatic logic [DW-1:0] flag(input logic h, input logic v);
        return {1'b1, 1'b0, v, h, 4'b0000, 2'b00};
    endfunction

    function automatic logic vblank_line(input int l);
        return (l == 0) || (l >= BSTART);
    endfunction

    task automatic put(inout int idx, input logic [DW-1:0] w, input logic de, input int req);
        stm[idx] = w; xde[idx] = de; xreq[idx] = req; xhs[idx] = 1'b0; xvs[idx] = 1'b0;
        idx++;
    endtask

    task automatic build();
        int idx = 0;
        for (int i = 0; i < LEAD_IN; i++) put(idx, 10'h040, 1'b0, 4);
        for (int l = 0; l < NLINE; l++) begin
            logic          vb  = vblank_line(l);
            // R2: line 2 codes carry nonzero low bits in preamble words
            logic [DW-1:0] ff  = (l == 2) ? 10'h3FF : 10'h3FC;
            logic [DW-1:0] zz  = (l == 2) ? 10'h003 : 10'h000;
            int            creq = (l == 2) ? 2 : 4;
            int            areq = vb ? 5 : ((l == 1) ? 6 : 4);  // R5 blank lines, R6 partial preamble
            eidx[l] = idx;
            put(idx, ff, 1'b0, creq);
            put(idx, zz, 1'b0, creq);
            put(idx, zz, 1'b0, creq);
            put(idx, flag(1'b1, vb), 1'b0, creq);
            for (int k = 0; k < NBLANK; k++) put(idx, 10'h040, 1'b0, 4);
            put(idx, ff, 1'b0, creq);
            put(idx, zz, 1'b0, creq);
            put(idx, zz, 1'b0, creq);
            put(idx, flag(1'b0, vb), 1'b0, creq);
            for (int k = 0; k < NACT; k++) begin
                logic [DW-1:0] w = 10'h200 + DW'(l * 8 + k);
                if (l == 1 && k == 1) w = 10'h3FC;   // R6: 0xFF, 0x00, then non-zero
                if (l == 1 && k == 2) w = 10'h000;
                if (l == 1 && k == 3) w = 10'h100;
                put(idx, w, !vb, areq);
            end
        end
        for (int i = 0; i < TAIL; i++) put(idx, 10'h040, 1'b0, 4);
        nwords = idx;
        if (hl != 0) begin
            for (int l = 0; l < NLINE; l++)
                for (int k = 0; k < int'(hl); k++) xhs[eidx[l] + int'(hg) + k] = 1'b1;
            for (int l = BSTART + int'(vg); l < BSTART + int'(vg) + int'(vl); l++)
                for (int i = eidx[l] + int'(hg); i < eidx[l + 1] + int'(hg); i++) xvs[i] = 1'b1;
        end
    endtask

    // monitor: pops each expectation 4 clocks after its word was driven
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].stamp + 4 == cyc) begin
            item_t it;
            it = sb.pop_front();
            chk_word(3, vid_o, it.d);                // R3
            chk_bit("de_o", it.de_req, de_o, it.de);
            chk_bit("hs_o", it.hs_req, hs_o, it.hs);
            chk_bit("vs_o", it.vs_req, vs_o, it.vs);
        end
    end

    task automatic run_case(input int g1, input int w1, input int g2, input int w2,
                            input logic i1, input logic i2);
        hg = CW'(g1); hl = CW'(w1); vg = CW'(g2); vl = CW'(w2); hinv = i1; vinv = i2;
        vid = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk_bit("de_o reset", 1, de_o, 1'b0);
        chk_word(1, vid_o, '0);
        chk_bit("hs_o reset", 1, hs_o, hinv);
        chk_bit("vs_o reset", 1, vs_o, vinv);
        @(posedge clk);
        #1 rst = 1'b0;
        build();
        for (int i = 0; i < nwords; i++) begin
            item_t it;
            @(posedge clk);
            #1 vid = stm[i];
            it.stamp  = cyc;
            it.d      = stm[i];
            it.de     = xde[i];
            it.hs     = xhs[i] ^ hinv;
            it.vs     = xvs[i] ^ vinv;
            it.de_req = xreq[i];
            it.hs_req = (w1 == 0) ? 7 : (i1 ? 8 : 7);          // R7 / R8
            it.vs_req = (w1 == 0 || w2 == 0) ? 10 : (i2 ? 8 : 9); // R10 / R8 / R9
            sb.push_back(it);
        end
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #1 vid = 10'h040;
        end
    endtask

    initial begin
        run_case(2, 3, 1, 2, 1'b0, 1'b0);  // R7 R9 plain pulses
        run_case(0, 1, 0, 1, 1'b1, 1'b1);  // R8 inverted, zero gaps
        run_case(5, 0, 0, 2, 1'b0, 1'b1);  // R7 R10 zero horizontal width
        run_case(3, 4, 2, 0, 1'b1, 1'b0);  // R10 zero vertical width
        repeat (5) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule